// File: doc/BRIEF.md
# Paired Serial Character FIFOs with Fill-Level Word

This block holds the characters that a serial port moves between a bus host and its line logic. A transmit queue of 16 bytes is filled by the host and drained by the transmitter one byte at a time. A receive queue of 16 ten-bit entries is filled by the receiver and drained by the host. Each receive entry keeps the character together with the parity and framing error flags that the receiver found for it.

The host works the block through two words. A small control word turns FIFO operation on and starts a flush of either queue. Each flush request reads back as set while it is pending and clears itself once the queue is empty. A read-only index word reports the fill level of both queues. Level outputs and one-cycle event pulses go to a neighbouring interrupt block. These cover transmit almost empty, receive almost full, receive overrun and transmit underrun.

Top module: `serial_fifo_pair`

## Requirements
- R1: After reset both counts are 0, the control word reads 0, the index word reads 0, `tx_almost_empty` is 1, and `rx_almost_full`, `rx_overrun` and `tx_underrun` are 0.
- R2: While control bit 0 (enable) is 0, pushes and pops on both queues are ignored: counts stay unchanged and neither event pulse fires.
- R3: The transmit queue returns bytes in write order. `tx_rdata` always shows the oldest byte, and a pop moves to the next one.
- R4: A receive entry reads back as bits 7:0 data, bit 8 parity error and bit 9 frame error, and entries come back in arrival order.
- R5: The index word carries the transmit count (0 to 16) in bits 4:0 and the receive count in bits 12:8. All its other bits read 0.
- R6: Writing control bit 2 flushes the receive queue, and writing bit 3 flushes the transmit queue. The request bit reads 1 for one cycle after the write. At the next edge the queue's count becomes 0 and the bit reads 0 again. Control bit 0 reads back the enable.
- R7: A receive push while the receive queue holds 16 entries is dropped. The contents stay unchanged, and `rx_overrun` is high for exactly the one cycle after that edge.
- R8: A transmit pop while enabled and with the transmit queue empty raises `tx_underrun` for exactly the one cycle after that edge.
- R9: `tx_almost_empty` is 1 when the transmit count is 4 or less. `rx_almost_full` is 1 when the receive count is 12 or more.
- R10: A push and a pop on a queue in the same cycle, neither full nor empty, leave its count unchanged, and the order is kept.
- R11: A push or pop presented during a pending flush cycle is ignored. The flush wins.
- R12: A transmit push while the transmit queue holds 16 bytes is dropped, and the count stays 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control write data: bit0 enable, bit2 receive flush, bit3 transmit flush |
| ctrl_rdata | output | 4 | Control word readback |
| index_word | output | 16 | Fill levels: transmit in 4:0, receive in 12:8 |
| tx_push | input | 1 | Host writes a byte to the transmit queue |
| tx_wdata | input | 8 | Byte to enqueue |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_rdata | output | 8 | Head byte of the transmit queue |
| rx_push | input | 1 | Receiver delivers a character |
| rx_wdata | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag for the character |
| rx_ferr | input | 1 | Frame error flag for the character |
| rx_pop | input | 1 | Host takes the head entry |
| rx_rdata | output | 10 | Head receive entry {frame, parity, data} |
| tx_almost_empty | output | 1 | Transmit count at or below its low level |
| rx_almost_full | output | 1 | Receive count at or above its high level |
| rx_overrun | output | 1 | One-cycle pulse for a dropped receive character |
| tx_underrun | output | 1 | One-cycle pulse for a pop from an empty transmit queue |

## Verification
Counts, the index word, the level outputs and the control readback change at the clock edge that samples a push, a pop or a control write, so they are due one edge after the stimulus. The flush lands one edge later, because the request bit is registered first and then acted on. Overrun and underrun pulses are registered: each is high only in the cycle after the offending edge and low again after the next one. The bench drives inputs and samples outputs on the falling edge, so every check falls in the half-cycle where the value is due. The pulses are checked in both their high cycle and the cycle that follows.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   localparam int CTRL_W      = 4;
   localparam int CB_ENABLE   = 0;
   localparam int CB_RX_FLUSH = 2;
   localparam int CB_TX_FLUSH = 3;
   localparam int IDX_W       = 16;
   localparam int IDX_TX_LSB  = 0;
   localparam int IDX_RX_LSB  = 8;
   localparam int IDX_FIELD_W = 5;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sfifo_store: DEPTH must be a power of two, at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sfifo_store: W must be positive");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             is_full, is_empty, do_push, do_pop;

   assign is_full  = (count == CNT_W'(DEPTH));
   assign is_empty = (count == '0);
   assign do_push  = en & push & ~is_full & ~flush;
   assign do_pop   = en & pop & ~is_empty & ~flush;
   assign rdata    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (do_push) begin
         mem[wr_ptr] <= wdata;
      end
   end

   // R10: simultaneous push and pop keeps the count
   a_r10_pushpop_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (en && push && pop && !flush && count != '0 && count != CNT_W'(DEPTH)) |=> $stable(count));
   // R6: a flush empties the queue at the next edge
   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));
   // R2: disabled queue holds its count
   a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !flush) |=> $stable(count));
   // R12 / R7: a full queue never grows beyond its depth
   a_r12_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH) && !flush && !(en && pop)) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/sfifo_level_mon.sv
module sfifo_level_mon #(
   parameter int CNT_W       = 5,
   parameter int LEVEL       = 4,
   parameter bit AT_OR_BELOW = 1'b1
) (
   input  logic [CNT_W-1:0] count,
   output logic             hit
);
   generate
      if (LEVEL < 0 || LEVEL >= (1 << CNT_W)) begin : g_bad_level
         $error("sfifo_level_mon: LEVEL out of count range");
      end
      if (AT_OR_BELOW) begin : g_low
         assign hit = (count <= CNT_W'(LEVEL));
      end else begin : g_high
         assign hit = (count >= CNT_W'(LEVEL));
      end
   endgenerate
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
   import sfifo_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   output logic              enable,
   output logic              rx_flush,
   output logic              tx_flush
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable   <= 1'b0;
         rx_flush <= 1'b0;
         tx_flush <= 1'b0;
      end else begin
         if (ctrl_wr) enable <= ctrl_wdata[CB_ENABLE];
         rx_flush <= ctrl_wr & ctrl_wdata[CB_RX_FLUSH];
         tx_flush <= ctrl_wr & ctrl_wdata[CB_TX_FLUSH];
      end
   end

   always_comb begin
      ctrl_rdata              = '0;
      ctrl_rdata[CB_ENABLE]   = enable;
      ctrl_rdata[CB_RX_FLUSH] = rx_flush;
      ctrl_rdata[CB_TX_FLUSH] = tx_flush;
   end

   // R6: a flush request clears itself unless rewritten
   a_r6_rx_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flush && !(ctrl_wr && ctrl_wdata[CB_RX_FLUSH])) |=> !rx_flush);
   a_r6_tx_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flush && !(ctrl_wr && ctrl_wdata[CB_TX_FLUSH])) |=> !tx_flush);
endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
   import sfifo_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TX_DEPTH    = 16,
   parameter int RX_DEPTH    = 16,
   parameter int TX_AE_LEVEL = 4,
   parameter int RX_AF_LEVEL = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   output logic [IDX_W-1:0]  index_word,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_rdata,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_wdata,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_pop,
   output logic [DATA_W+1:0] rx_rdata,
   output logic              tx_almost_empty,
   output logic              rx_almost_full,
   output logic              rx_overrun,
   output logic              tx_underrun
);
   localparam int TX_CW = $clog2(TX_DEPTH + 1);
   localparam int RX_CW = $clog2(RX_DEPTH + 1);
   localparam int RX_W  = DATA_W + 2;

   generate
      if (TX_CW > IDX_FIELD_W || RX_CW > IDX_FIELD_W) begin : g_bad_idx
         $error("serial_fifo_pair: depth too large for the index fields");
      end
   endgenerate

   logic             enable, rx_flush, tx_flush;
   logic [TX_CW-1:0] tx_cnt;
   logic [RX_CW-1:0] rx_cnt;
   logic             rx_drop, tx_starve;

   sfifo_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (ctrl_wr),
      .ctrl_wdata (ctrl_wdata),
      .ctrl_rdata (ctrl_rdata),
      .enable     (enable),
      .rx_flush   (rx_flush),
      .tx_flush   (tx_flush)
   );

   sfifo_store #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_q (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .flush (tx_flush),
      .push  (tx_push),
      .wdata (tx_wdata),
      .pop   (tx_pop),
      .rdata (tx_rdata),
      .count (tx_cnt)
   );

   sfifo_store #(.W(RX_W), .DEPTH(RX_DEPTH)) u_rx_q (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .flush (rx_flush),
      .push  (rx_push),
      .wdata ({rx_ferr, rx_perr, rx_wdata}),
      .pop   (rx_pop),
      .rdata (rx_rdata),
      .count (rx_cnt)
   );

   sfifo_level_mon #(.CNT_W(TX_CW), .LEVEL(TX_AE_LEVEL), .AT_OR_BELOW(1'b1)) u_tx_low (
      .count (tx_cnt),
      .hit   (tx_almost_empty)
   );

   sfifo_level_mon #(.CNT_W(RX_CW), .LEVEL(RX_AF_LEVEL), .AT_OR_BELOW(1'b0)) u_rx_high (
      .count (rx_cnt),
      .hit   (rx_almost_full)
   );

   always_comb begin
      index_word = '0;
      index_word[IDX_TX_LSB +: TX_CW] = tx_cnt;
      index_word[IDX_RX_LSB +: RX_CW] = rx_cnt;
   end

   assign rx_drop   = enable & rx_push & ~rx_flush & (rx_cnt == RX_CW'(RX_DEPTH));
   assign tx_starve = enable & tx_pop & ~tx_flush & (tx_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_overrun  <= 1'b0;
         tx_underrun <= 1'b0;
      end else begin
         rx_overrun  <= rx_drop;
         tx_underrun <= tx_starve;
      end
   end

   // R7: overrun only follows a cycle in which the receive queue was full
   a_r7_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> $past(rx_cnt == RX_CW'(RX_DEPTH)));
   // R8: underrun only follows a cycle with an empty transmit queue
   a_r8_underrun_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |-> $past(tx_cnt == '0));
   // R2: no event pulse follows a disabled cycle
   a_r2_no_event_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun || tx_underrun) |-> $past(enable));
   // R7: a dropped character leaves the receive queue full
   a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_drop && !rx_pop) |=> (rx_cnt == RX_CW'(RX_DEPTH)));
endmodule

// File: tb/serial_fifo_pair_tb.sv
module serial_fifo_pair_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_wr = 1'b0;
   logic [3:0] ctrl_wdata = '0;
   logic [3:0] ctrl_rdata;
   logic [15:0] index_word;
   logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata;
   logic       rx_perr = 1'b0, rx_ferr = 1'b0;
   logic [9:0] rx_rdata;
   logic       tx_almost_empty, rx_almost_full, rx_overrun, tx_underrun;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   serial_fifo_pair u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .index_word(index_word), .tx_push(tx_push),
      .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .tx_almost_empty(tx_almost_empty), .rx_almost_full(rx_almost_full),
      .rx_overrun(rx_overrun), .tx_underrun(tx_underrun)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [4:0] txc; return index_word[4:0]; endfunction
   function automatic logic [4:0] rxc; return index_word[12:8]; endfunction

   task automatic ctrl_write(input logic [3:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v; tick; ctrl_wr = 1'b0; ctrl_wdata = '0;
   endtask

   task automatic tx_put(input logic [7:0] b);
      tx_push = 1'b1; tx_wdata = b; tick; tx_push = 1'b0;
   endtask

   task automatic rx_put(input logic [7:0] d, input logic p, input logic f);
      rx_push = 1'b1; rx_wdata = d; rx_perr = p; rx_ferr = f; tick;
      rx_push = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "index", index_word, 0);
      chk("R1", "ctrl", ctrl_rdata, 0);
      chk("R1", "tx_ae", tx_almost_empty, 1);
      chk("R1", "rx_af", rx_almost_full, 0);
      chk("R1", "events", {rx_overrun, tx_underrun}, 0);
   endtask

   task automatic t_disabled;
      tx_put(8'h11);
      rx_put(8'h22, 1'b0, 1'b0);
      tx_pop = 1'b1; rx_pop = 1'b1; tick; tx_pop = 1'b0; rx_pop = 1'b0;
      chk("R2", "index stays 0", index_word, 0);
      chk("R2", "no underrun", tx_underrun, 0);
      chk("R2", "no overrun", rx_overrun, 0);
   endtask

   task automatic t_tx_order;
      for (int i = 0; i < 6; i++) begin
         tx_put(8'hA0 + 8'(i));
         chk("R5", "tx count", txc(), i + 1);
         chk("R9", "tx almost empty", tx_almost_empty, (i + 1 <= 4) ? 1 : 0);
      end
      for (int i = 0; i < 6; i++) begin
         chk("R3", "tx head", tx_rdata, 8'hA0 + 8'(i));
         tx_pop = 1'b1; tick; tx_pop = 1'b0;
         chk("R3", "tx count after pop", txc(), 5 - i);
      end
      chk("R8", "no underrun on valid pops", tx_underrun, 0);
   endtask

   task automatic t_rx_flags;
      rx_put(8'h55, 1'b0, 1'b0);
      rx_put(8'hAA, 1'b1, 1'b0);
      rx_put(8'h0F, 1'b0, 1'b1);
      rx_put(8'hF0, 1'b1, 1'b1);
      chk("R5", "rx count", rxc(), 4);
      chk("R5", "unused index bits", {index_word[15:13], index_word[7:5]}, 0);
      chk("R4", "entry0", rx_rdata, 10'h055);
      rx_pop = 1'b1; tick;
      chk("R4", "entry1", rx_rdata, 10'h1AA); tick;
      chk("R4", "entry2", rx_rdata, 10'h20F); tick;
      chk("R4", "entry3", rx_rdata, 10'h3F0); tick;
      rx_pop = 1'b0;
      chk("R4", "rx drained", rxc(), 0);
   endtask

   task automatic t_rx_fill;
      for (int i = 0; i < 16; i++) begin
         rx_put(8'(i), 1'b0, 1'b0);
         chk("R9", "rx almost full", rx_almost_full, (i + 1 >= 12) ? 1 : 0);
      end
      chk("R5", "rx count full", rxc(), 16);
      rx_put(8'h77, 1'b0, 1'b0);
      chk("R7", "overrun pulse", rx_overrun, 1);
      chk("R7", "count kept", rxc(), 16);
      chk("R7", "head kept", rx_rdata, 10'h000);
      tick;
      chk("R7", "overrun one cycle", rx_overrun, 0);
   endtask

   task automatic t_tx_full;
      for (int i = 0; i < 17; i++) tx_put(8'(i + 1));
      chk("R12", "tx count capped", txc(), 16);
      chk("R12", "tx head", tx_rdata, 8'h01);
      chk("R9", "tx not almost empty", tx_almost_empty, 0);
   endtask

   task automatic t_flush;
      ctrl_write(4'b0101);
      chk("R6", "rx flush pending readback", ctrl_rdata, 4'b0101);
      chk("R6", "rx not yet flushed", rxc(), 16);
      tick;
      chk("R6", "rx flush self-cleared", ctrl_rdata, 4'b0001);
      chk("R6", "rx flushed", rxc(), 0);
      chk("R6", "tx untouched", txc(), 16);
      rx_put(8'h01, 1'b0, 1'b0);
      rx_put(8'h02, 1'b0, 1'b0);
      ctrl_write(4'b0101);
      rx_push = 1'b1; rx_wdata = 8'h05; tick; rx_push = 1'b0;
      chk("R11", "push during flush ignored", rxc(), 0);
      ctrl_write(4'b1001);
      chk("R6", "tx flush pending readback", ctrl_rdata, 4'b1001);
      tx_pop = 1'b1; tick; tx_pop = 1'b0;
      chk("R11", "tx flushed despite pop", txc(), 0);
      chk("R6", "tx flush self-cleared", ctrl_rdata, 4'b0001);
      chk("R11", "no underrun during flush", tx_underrun, 0);
   endtask

   task automatic t_pushpop;
      rx_put(8'h31, 1'b0, 1'b0);
      rx_put(8'h32, 1'b0, 1'b0);
      rx_put(8'h33, 1'b0, 1'b0);
      rx_push = 1'b1; rx_wdata = 8'h34; rx_pop = 1'b1; tick;
      rx_push = 1'b0; rx_pop = 1'b0;
      chk("R10", "count unchanged", rxc(), 3);
      chk("R10", "head advanced", rx_rdata, 10'h032);
      rx_pop = 1'b1; tick;
      chk("R10", "second", rx_rdata, 10'h033); tick;
      chk("R10", "pushed entry last", rx_rdata, 10'h034); tick;
      rx_pop = 1'b0;
   endtask

   task automatic t_underrun;
      tx_pop = 1'b1; tick; tx_pop = 1'b0;
      chk("R8", "underrun pulse", tx_underrun, 1);
      tick;
      chk("R8", "underrun one cycle", tx_underrun, 0);
      ctrl_write(4'b0000);
      chk("R6", "enable readback 0", ctrl_rdata, 0);
      tx_pop = 1'b1; tick; tx_pop = 1'b0;
      chk("R2", "no underrun when disabled", tx_underrun, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_disabled;
      ctrl_write(4'b0001);
      chk("R6", "enable readback", ctrl_rdata, 4'b0001);
      t_tx_order;
      t_rx_flags;
      t_rx_fill;
      t_tx_full;
      t_flush;
      t_pushpop;
      t_underrun;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule